// File: doc/BRIEF.md
# Recursive Trapezoidal Shaping Filter

This block shapes a stream of signed ADC samples taken from a detector whose pulses arrive as steps. For every accepted sample it produces one filtered value: the sum of the newest `L` samples minus the sum of an older window of `L` samples. The older window ends `L+G` samples before the newest sample, so the two windows are separated by a gap of `G` samples. When a step arrives, the output rises over `L` samples, holds a flat top, and falls back over `L` samples. The height of the trapezoid is proportional to the step height. The result is not divided by `L`, so a downstream stage decides how to scale it.

The filter does not add up both windows again on every sample. It keeps a running value and, for each sample, adds the newest sample, subtracts the samples `L` and `L+G` back, and adds back the sample `2L+G` back. The delayed samples come from two ring-buffer delay lines in series. The first line taps the input at `L` and at `L+G`. The second line is fed from the `L+G` tap and delays it by a further `L`. Length and gap are set at run time. Any change to their effective values restarts the filter from empty. Out-of-range settings are clamped to the nearest legal pair, and the pair in use is reported on two outputs.

Top module: `tz_shaper`

## Requirements
- R1: While `out_valid` is high, `out_data` equals the sum of the newest `L` accepted samples minus the sum of the `L` accepted samples ending `L+G` samples before the newest. All weights are one, no division is applied, and samples from before the last clear count as zero.
- R2: Each sample accepted at a rising edge of `clk` (`in_valid` high and no clear in that cycle) produces its output in `out_data`/`out_valid` at that same edge. The output is visible from then until the next edge. Exactly one output is produced per accepted sample.
- R3: `out_data` is `DATA_W+SPAN_W+1` bits wide. Full-scale inputs of either sign, at the largest legal length, give exact results without wrap-around.
- R4: The effective pair is derived from the requested pair `cfg_len`/`cfg_gap` as follows. A requested length of 0 becomes 1. If length plus gap exceeds `2**SPAN_W-1`, the gap is reduced to `2**SPAN_W-1` minus the length. `act_len`/`act_gap` show the effective pair one edge after a change.
- R5: When the effective pair differs from the pair in use, the next edge loads the new pair and empties both delay lines. On the following cycle `out_valid` is 0 and `out_data` is 0. A sample presented in that change cycle is discarded.
- R6: After a clear, `out_valid` stays low until `2L+G` samples have been accepted. It goes high on the output of the `2L+G`-th sample.
- R7: A cycle with `in_valid` low produces no output (`out_valid` is 0 after that edge) and leaves `out_data` and the delay lines unchanged.
- R8: For an input that steps from 0 to `A` at accepted sample `s` (with at least `2L+G` zeros before it), let `j` be the index of the current accepted sample minus `s`. The output is `A*(j+1)` for `0<=j<L`, equals `L*A` for `L<=j<L+G`, equals `A*(2L+G-1-j)` for `L+G<=j<2L+G`, and is 0 from then on.
- R9: While `rst` is high, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | SPAN_W | Requested window length L |
| cfg_gap | input | SPAN_W | Requested gap G |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DATA_W | Signed ADC sample |
| out_valid | output | 1 | Filtered value present |
| out_data | output | DATA_W+SPAN_W+1 | Signed filtered value, scaled by L |
| act_len | output | SPAN_W | Length in use after clamping |
| act_gap | output | SPAN_W | Gap in use after clamping |

## Verification
The bench builds the filter with `DATA_W=8` and `SPAN_W=6`, which caps `L+G` at 63. With that cap, the clamp rule can be reached with small settings, and the longest legal window (`L=63`, `G=0`) fills in 126 samples. Full-scale inputs at that length reach the edge of the 15-bit output range, which tests the width rule directly. Random streams are run with several length and gap pairs, including `G=0` and `L=1`. Further runs cover a step input checked against the trapezoid formula, streams with idle cycles between samples, and a setting change in the middle of a stream.

// File: rtl/tz_pkg.sv
package tz_pkg;

    localparam int unsigned DEF_DATA_W = 14;
    localparam int unsigned DEF_SPAN_W = 10;

    // tap order inside the first delay line
    typedef enum int unsigned {
        TAP_FAR  = 0,
        TAP_NEAR = 1
    } tap_e;

    function automatic int unsigned span_max(input int unsigned w);
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic int unsigned acc_width(input int unsigned dw, input int unsigned sw);
        return dw + sw + 1;
    endfunction

endpackage

// File: rtl/tz_cfg.sv
module tz_cfg
    import tz_pkg::*;
#(
    parameter int unsigned SPAN_W = DEF_SPAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPAN_W-1:0] req_len,
    input  logic [SPAN_W-1:0] req_gap,
    output logic [SPAN_W-1:0] act_len,
    output logic [SPAN_W-1:0] act_gap,
    output logic              clr
);
    localparam logic [SPAN_W:0]   LIMIT_W = (SPAN_W+1)'(span_max(SPAN_W));
    localparam logic [SPAN_W-1:0] LIMIT_N = SPAN_W'(span_max(SPAN_W));

    logic [SPAN_W-1:0] len_c;
    logic [SPAN_W-1:0] gap_c;
    logic [SPAN_W:0]   span_sum;

    always_comb begin
        len_c    = (req_len == '0) ? SPAN_W'(1) : req_len;
        span_sum = {1'b0, len_c} + {1'b0, req_gap};
        gap_c    = (span_sum > LIMIT_W) ? (LIMIT_N - len_c) : req_gap;
        clr      = (len_c != act_len) || (gap_c != act_gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_len <= '0;
            act_gap <= '0;
        end else if (clr) begin
            act_len <= len_c;
            act_gap <= gap_c;
        end
    end

endmodule

// File: rtl/tz_delay.sv
module tz_delay
    import tz_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_SPAN_W,
    parameter int unsigned NTAP   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          push,
    input  logic [DATA_W-1:0]             din,
    input  logic [NTAP-1:0][ADDR_W-1:0]   tap_dly,
    output logic [NTAP-1:0][DATA_W-1:0]   tap_q
);
    localparam int unsigned       DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FILL_TOP = '1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            fill <= '0;
        end else if (push) begin
            wptr <= wptr + ADDR_W'(1);
            if (fill != FILL_TOP) fill <= fill + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    // each tap reads the word written tap_dly pushes ago; empty slots read zero
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        logic [ADDR_W-1:0] raddr;
        assign raddr    = wptr - tap_dly[t];
        assign tap_q[t] = (fill >= tap_dly[t]) ? mem[raddr] : '0;
    end

endmodule

// File: rtl/tz_acc.sv
module tz_acc
    import tz_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ACC_W  = acc_width(DEF_DATA_W, DEF_SPAN_W),
    parameter int unsigned CNT_W  = DEF_SPAN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     push,
    input  logic signed [DATA_W-1:0] v_now,
    input  logic signed [DATA_W-1:0] v_near,
    input  logic signed [DATA_W-1:0] v_far,
    input  logic signed [DATA_W-1:0] v_old,
    input  logic [CNT_W-1:0]         need,
    output logic signed [ACC_W-1:0]  acc,
    output logic                     acc_valid
);
    logic [CNT_W-1:0]        seen;
    logic [CNT_W-1:0]        seen_nx;
    logic signed [ACC_W-1:0] acc_nx;

    function automatic logic signed [ACC_W-1:0] sx(input logic signed [DATA_W-1:0] v);
        return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
    endfunction

    always_comb begin
        seen_nx = seen + CNT_W'(1);
        acc_nx  = acc + sx(v_now) - sx(v_near) - sx(v_far) + sx(v_old);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc       <= '0;
            seen      <= '0;
            acc_valid <= 1'b0;
        end else if (push) begin
            acc       <= acc_nx;
            seen      <= (seen_nx >= need) ? need : seen_nx;
            acc_valid <= (seen_nx >= need);
        end else begin
            acc_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tz_shaper.sv
module tz_shaper
    import tz_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned SPAN_W = DEF_SPAN_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [SPAN_W-1:0]                 cfg_len,
    input  logic [SPAN_W-1:0]                 cfg_gap,
    input  logic                              in_valid,
    input  logic signed [DATA_W-1:0]          in_data,
    output logic                              out_valid,
    output logic signed [DATA_W+SPAN_W:0]     out_data,
    output logic [SPAN_W-1:0]                 act_len,
    output logic [SPAN_W-1:0]                 act_gap
);
    localparam int unsigned ACC_W = acc_width(DATA_W, SPAN_W);
    localparam int unsigned CNT_W = SPAN_W + 1;

    logic                           clr;
    logic                           push;
    logic [1:0][SPAN_W-1:0]         dly1;
    logic [1:0][DATA_W-1:0]         q1;
    logic [0:0][SPAN_W-1:0]         dly2;
    logic [0:0][DATA_W-1:0]         q2;
    logic [CNT_W-1:0]               need;
    logic signed [ACC_W-1:0]        acc;

    tz_cfg #(.SPAN_W(SPAN_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .req_len (cfg_len),
        .req_gap (cfg_gap),
        .act_len (act_len),
        .act_gap (act_gap),
        .clr     (clr)
    );

    assign push = in_valid && !clr;

    // L+G never exceeds the span limit after clamping, so the sum fits SPAN_W bits
    assign dly1[TAP_FAR]  = act_len + act_gap;
    assign dly1[TAP_NEAR] = act_len;
    assign dly2[0]        = act_len;
    assign need           = ({1'b0, act_len} << 1) + {1'b0, act_gap};

    tz_delay #(.DATA_W(DATA_W), .ADDR_W(SPAN_W), .NTAP(2)) u_line_a (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .push    (push),
        .din     (in_data),
        .tap_dly (dly1),
        .tap_q   (q1)
    );

    tz_delay #(.DATA_W(DATA_W), .ADDR_W(SPAN_W), .NTAP(1)) u_line_b (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .push    (push),
        .din     (q1[TAP_FAR]),
        .tap_dly (dly2),
        .tap_q   (q2)
    );

    tz_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push      (push),
        .v_now     (in_data),
        .v_near    ($signed(q1[TAP_NEAR])),
        .v_far     ($signed(q1[TAP_FAR])),
        .v_old     ($signed(q2[0])),
        .need      (need),
        .acc       (acc),
        .acc_valid (out_valid)
    );

    assign out_data = acc;

endmodule

// File: rtl/tz_shaper_chk.sv
module tz_shaper_chk
    import tz_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned SPAN_W = DEF_SPAN_W
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          clr,
    input logic                          out_valid,
    input logic signed [DATA_W+SPAN_W:0] out_data,
    input logic [SPAN_W-1:0]             act_len,
    input logic [SPAN_W-1:0]             act_gap
);
    localparam logic [SPAN_W:0] LIMIT_W = (SPAN_W+1)'(span_max(SPAN_W));

    logic [SPAN_W+1:0] taken;
    logic [SPAN_W+1:0] need_w;

    assign need_w = ({2'b0, act_len} << 1) + {2'b0, act_gap};

    always_ff @(posedge clk) begin
        if (rst || clr) taken <= '0;
        else if (in_valid && taken != '1) taken <= taken + 1'b1;
    end

    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (act_len != '0 && ({1'b0, act_len} + {1'b0, act_gap}) <= LIMIT_W)); // R4

    AST_VALID_FROM_PUSH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && !clr)); // R2

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!out_valid && out_data == '0)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> (!out_valid && $stable(out_data))); // R7

    AST_FILL_FIRST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (taken >= need_w)); // R6

endmodule

bind tz_shaper tz_shaper_chk #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .clr       (clr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .act_len   (act_len),
    .act_gap   (act_gap)
);

// File: tb/sim_tz_shaper.sv
module sim_tz_shaper;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned SPAN_W = 6;
    localparam int unsigned OUT_W  = DATA_W + SPAN_W + 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [SPAN_W-1:0]        cfg_len = SPAN_W'(2);
    logic [SPAN_W-1:0]        cfg_gap = SPAN_W'(2);
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic                     out_valid;
    logic signed [OUT_W-1:0]  out_data;
    logic [SPAN_W-1:0]        act_len;
    logic [SPAN_W-1:0]        act_gap;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    int hist [0:2047];
    int nacc = 0;
    int cur_l = 1;
    int cur_g = 0;
    bit pend = 0;
    bit pend_v = 0;
    int pend_val = 0;
    string pend_tag = "";

    // step shape override
    bit shape_on = 0;
    int shape_s = 0;
    int shape_a = 0;

    always #10 clk = ~clk;

    tz_shaper #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_len   (cfg_len),
        .cfg_gap   (cfg_gap),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .act_len   (act_len),
        .act_gap   (act_gap)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int ref_out(input int k);
        int s = 0;
        for (int i = k - cur_l + 1; i <= k; i++)
            if (i >= 0) s += hist[i];
        for (int i = k - 2*cur_l - cur_g + 1; i <= k - cur_l - cur_g; i++)
            if (i >= 0) s -= hist[i];
        return s;
    endfunction

    function automatic int shape_out(input int k);
        int j = k - shape_s;
        if (j < 0) return 0;
        if (j < cur_l) return shape_a * (j + 1);
        if (j < cur_l + cur_g) return shape_a * cur_l;
        if (j < 2*cur_l + cur_g) return shape_a * (2*cur_l + cur_g - 1 - j);
        return 0;
    endfunction

    task automatic check_pending();
        if (pend) begin
            check(out_valid == pend_v, {pend_tag, " out_valid"}, int'(out_valid), int'(pend_v));
            if (pend_v) check(int'(out_data) == pend_val, {pend_tag, " out_data"}, int'(out_data), pend_val);
        end
        pend = 0;
    endtask

    task automatic step(input bit v, input int s, input string tag);
        @(negedge clk);
        check_pending();
        in_valid = v;
        in_data  = DATA_W'(s);
        if (v) begin
            hist[nacc] = s;
            pend_val = shape_on ? shape_out(nacc) : ref_out(nacc);
            nacc++;
            pend_v = (nacc >= 2*cur_l + cur_g);
        end else begin
            pend_v = 0;
        end
        pend_tag = tag;
        pend = 1;
    endtask

    // change settings; vchg drives a sample during the change cycle that must be dropped
    task automatic set_cfg(input int l, input int g, input int el, input int eg, input bit vchg);
        @(negedge clk);
        check_pending();
        cfg_len  = SPAN_W'(l);
        cfg_gap  = SPAN_W'(g);
        in_valid = vchg;
        in_data  = DATA_W'(99);
        @(negedge clk);
        in_valid = 0;
        check(int'(act_len) == el, "R4 act_len", int'(act_len), el);
        check(int'(act_gap) == eg, "R4 act_gap", int'(act_gap), eg);
        check(out_valid == 1'b0, "R5 valid after clear", int'(out_valid), 0);
        check(out_data == '0, "R5 data after clear", int'(out_data), 0);
        cur_l = el;
        cur_g = eg;
        nacc  = 0;
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic run_random(input int l, input int g, input int n, input string tag);
        set_cfg(l, g, l, g, 0);
        for (int i = 0; i < n; i++) step(1, rnd_sample(), tag);
        step(0, 0, tag);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
        check(out_data == '0, "R9 reset data", int'(out_data), 0);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic t_step();
        set_cfg(6, 4, 6, 4, 0);
        shape_on = 1;
        shape_s  = 16;
        shape_a  = 50;
        for (int i = 0; i < 16; i++) step(1, 0, "R8 step lead");
        for (int i = 0; i < 40; i++) step(1, 50, "R8 step shape");
        step(0, 0, "R8 step end");
        shape_on = 0;
    endtask

    task automatic t_idle();
        int out_seen;
        set_cfg(4, 2, 4, 2, 0);
        out_seen = 0;
        for (int i = 0; i < 60; i++) begin
            step(1, rnd_sample(), "R7 idle gaps");
            if (i % 3 == 1) begin
                step(0, 0, "R7 idle no output");
                @(negedge clk);
                check_pending();
                check(int'(out_data) == pend_val || nacc < 10, "R7 idle held value", int'(out_data), pend_val);
                in_valid = 0;
                pend = 0;
            end
        end
        step(0, 0, "R7 idle end");
    endtask

    task automatic t_extreme();
        set_cfg(63, 0, 63, 0, 0);
        for (int i = 0; i < 63; i++) step(1, -128, "R3 neg fill");
        for (int i = 0; i < 63; i++) step(1, 127, "R3 pos max");
        for (int i = 0; i < 63; i++) step(1, -128, "R3 neg max");
        step(0, 0, "R3 end");
    endtask

    task automatic t_clamp();
        set_cfg(0, 5, 1, 5, 0);
        for (int i = 0; i < 20; i++) step(1, rnd_sample(), "R4 clamp len zero");
        set_cfg(40, 40, 40, 23, 0);
        for (int i = 0; i < 120; i++) step(1, rnd_sample(), "R4 clamp span");
        step(0, 0, "R4 end");
    endtask

    task automatic t_midchange();
        set_cfg(3, 9, 3, 9, 0);
        for (int i = 0; i < 10; i++) step(1, rnd_sample(), "R6 partial fill");
        set_cfg(2, 1, 2, 1, 1);
        for (int i = 0; i < 30; i++) step(1, rnd_sample(), "R5 restart after change");
        step(0, 0, "R5 end");
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        t_reset();
        run_random(5, 3, 80, "R1 R2 random L5 G3");
        run_random(7, 0, 80, "R1 random gap zero");
        run_random(1, 0, 30, "R1 random L1 G0");
        t_step();
        t_idle();
        t_extreme();
        t_clamp();
        t_midchange();
        @(negedge clk);
        check_pending();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule